// File: doc/BRIEF.md
# Aliased Floating-Point / Vector Register File

This block holds the floating-point and vector state of a core in one array of wide entries, with a separate integer register bank beside it. Every wide entry can be reached in three widths: a 64-bit scalar view, a 128-bit short-vector view and a full 256-bit long-vector view. All three use the same entry number. The narrow views are the low bits of the wide entry, so they are aliases of it and not separate registers.

The array has two combinational read ports and one synchronous write port. Each port has its own view select. A narrow write merges into the low bits of the addressed entry and leaves the upper bits as they were. Any later read in any width sees the merged result. The integer bank has two read ports and one write port. Its register 0 is tied to zero, and its width is a parameter: 32 for the 32-bit variant, 64 for the 64-bit variant. A parameter chooses what a read returns when it addresses the entry being written in the same cycle: the old contents (default) or the new value through a bypass.

Top module: `vreg_alias_file`

## Requirements
- R1: The array has 32 entries of 256 bits, and the entry number is the same in every view. View encoding: 2'd0 selects the 64-bit view (bits 63:0), 2'd1 the 128-bit view (bits 127:0), 2'd2 and 2'd3 the full 256-bit view.
- R2: A 64-bit-view write replaces bits 63:0 of the entry and leaves bits 255:64 unchanged.
- R3: A 128-bit-view write replaces bits 127:0 of the entry and leaves bits 255:128 unchanged.
- R4: A 256-bit-view write replaces the whole entry with the write data.
- R5: A narrow-view read returns the low 64 or 128 bits of the entry, whatever width last wrote it, with the output bits above the view width driven to zero.
- R6: The two read ports are combinational and independent: each returns the entry selected by its own index and view in the same cycle.
- R7: With the default setting, a read that addresses the entry being written in the same cycle returns the contents from before the write. This applies to both banks. With the bypass setting, the read returns the value after the write.
- R8: Reset (active low, asynchronous) clears every array entry and every integer register to zero.
- R9: The integer bank has 32 registers of the parameter width. A write takes effect on the rising clock edge when its enable is high, and nothing changes when the enable is low. The same enable rule applies to the array.
- R10: Integer register 0 always reads as zero, and writes to it are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| vw_en | input | 1 | Array write enable |
| vw_idx | input | 5 | Array write entry |
| vw_view | input | 2 | Array write view |
| vw_data | input | 256 | Array write data (low bits used by narrow views) |
| vr0_idx | input | 5 | Array read port 0 entry |
| vr0_view | input | 2 | Array read port 0 view |
| vr0_data | output | 256 | Array read port 0 data, zero-extended |
| vr1_idx | input | 5 | Array read port 1 entry |
| vr1_view | input | 2 | Array read port 1 view |
| vr1_data | output | 256 | Array read port 1 data, zero-extended |
| gw_en | input | 1 | Integer write enable |
| gw_idx | input | 5 | Integer write register |
| gw_data | input | GPR_W | Integer write data |
| gr0_idx | input | 5 | Integer read port 0 register |
| gr0_data | output | GPR_W | Integer read port 0 data |
| gr1_idx | input | 5 | Integer read port 1 register |
| gr1_data | output | GPR_W | Integer read port 1 data |

## Verification
A merge with the wrong mask shows up as corrupted upper bits. A 256-bit read of the entry in the cycle after the narrow write exposes it, which is why the bench often reads back entries it has just written. A misrouted entry index or view select appears at once on the combinational read data for that entry. A broken read-first ordering shows as new data on a read that collides with a write in the same cycle. A register 0 that takes a write shows as a non-zero read of register 0 one cycle after that write.

// File: rtl/vra_pkg.sv
package vra_pkg;

    typedef enum logic [1:0] {
        VIEW_S64  = 2'd0,
        VIEW_V128 = 2'd1,
        VIEW_V256 = 2'd2,
        VIEW_V256X = 2'd3
    } view_e;

endpackage

// File: rtl/vra_view_sel.sv
module vra_view_sel
    import vra_pkg::*;
#(
    parameter int VEC_W = 256
) (
    input  view_e              view,
    input  logic [VEC_W-1:0]   entry,
    output logic [VEC_W-1:0]   mask,
    output logic [VEC_W-1:0]   masked
);
    localparam int QW = VEC_W / 4;
    localparam int HW = VEC_W / 2;
    localparam logic [VEC_W-1:0] MASK_Q = {{(VEC_W-QW){1'b0}}, {QW{1'b1}}};
    localparam logic [VEC_W-1:0] MASK_H = {{(VEC_W-HW){1'b0}}, {HW{1'b1}}};

    always_comb begin
        case (view)
            VIEW_S64:  mask = MASK_Q;
            VIEW_V128: mask = MASK_H;
            default:   mask = '1;
        endcase
        masked = entry & mask;
    end

endmodule

// File: rtl/vra_merge.sv
module vra_merge
    import vra_pkg::*;
#(
    parameter int VEC_W = 256
) (
    input  view_e              view,
    input  logic [VEC_W-1:0]   old_entry,
    input  logic [VEC_W-1:0]   new_data,
    output logic [VEC_W-1:0]   merged
);
    logic [VEC_W-1:0] mask;
    logic [VEC_W-1:0] new_low;

    vra_view_sel #(.VEC_W(VEC_W)) u_sel (
        .view   (view),
        .entry  (new_data),
        .mask   (mask),
        .masked (new_low)
    );

    always_comb begin
        merged = (old_entry & ~mask) | new_low;
    end

endmodule

// File: rtl/vra_fp_bank.sv
module vra_fp_bank
    import vra_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int VEC_W   = 256,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  view_e              wr_view,
    input  logic [VEC_W-1:0]   wr_data,
    output logic [VEC_W-1:0]   wr_merged,
    input  logic [IDX_W-1:0]   rd0_idx,
    output logic [VEC_W-1:0]   rd0_raw,
    input  logic [IDX_W-1:0]   rd1_idx,
    output logic [VEC_W-1:0]   rd1_raw
);
    localparam int QW = VEC_W / 4;
    localparam int HW = VEC_W / 2;

    typedef struct packed {
        logic [ENTRIES-1:0][VEC_W-1:0] ent;
    } fp_state_t;

    fp_state_t st_d, st_q;
    logic [VEC_W-1:0] wr_old;

    always_comb begin
        wr_old  = st_q.ent[wr_idx];
        rd0_raw = st_q.ent[rd0_idx];
        rd1_raw = st_q.ent[rd1_idx];
    end

    vra_merge #(.VEC_W(VEC_W)) u_merge (
        .view      (wr_view),
        .old_entry (wr_old),
        .new_data  (wr_data),
        .merged    (wr_merged)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ent[wr_idx] = wr_merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_S64_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_view == VIEW_S64) |=>
            st_q.ent[$past(wr_idx)][VEC_W-1:QW] == $past(wr_old[VEC_W-1:QW])); // R2

    AST_V128_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_view == VIEW_V128) |=>
            st_q.ent[$past(wr_idx)][VEC_W-1:HW] == $past(wr_old[VEC_W-1:HW])); // R3

    AST_V256_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_view == VIEW_V256 || wr_view == VIEW_V256X)) |=>
            st_q.ent[$past(wr_idx)] == $past(wr_data)); // R4

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (st_q.ent[0] == '0 && st_q.ent[ENTRIES-1] == '0)); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q)); // R9

endmodule

// File: rtl/vra_read_port.sv
module vra_read_port
    import vra_pkg::*;
#(
    parameter int  VEC_W       = 256,
    parameter int  IDX_W       = 5,
    parameter bit  WRITE_FIRST = 1'b0
) (
    input  logic [IDX_W-1:0]   rd_idx,
    input  view_e              rd_view,
    input  logic [VEC_W-1:0]   rd_raw,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VEC_W-1:0]   wr_merged,
    output logic [VEC_W-1:0]   rd_data
);
    logic [VEC_W-1:0] picked;
    logic [VEC_W-1:0] unused_mask;

    generate
        if (WRITE_FIRST) begin : g_bypass
            always_comb begin
                picked = (wr_en && wr_idx == rd_idx) ? wr_merged : rd_raw;
            end
        end else begin : g_old
            logic unused_wr;
            assign unused_wr = ^{wr_en, wr_idx, wr_merged, rd_idx};
            always_comb begin
                picked = rd_raw;
            end
        end
    endgenerate

    vra_view_sel #(.VEC_W(VEC_W)) u_sel (
        .view   (rd_view),
        .entry  (picked),
        .mask   (unused_mask),
        .masked (rd_data)
    );

endmodule

// File: rtl/vra_gp_bank.sv
module vra_gp_bank #(
    parameter int  ENTRIES     = 32,
    parameter int  GPR_W       = 64,
    parameter bit  WRITE_FIRST = 1'b0,
    localparam int IDX_W       = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [GPR_W-1:0]   wr_data,
    input  logic [IDX_W-1:0]   rd0_idx,
    output logic [GPR_W-1:0]   rd0_data,
    input  logic [IDX_W-1:0]   rd1_idx,
    output logic [GPR_W-1:0]   rd1_data
);
    typedef struct packed {
        logic [ENTRIES-1:0][GPR_W-1:0] r;
    } gp_state_t;

    gp_state_t st_d, st_q;
    logic      wr_live;

    always_comb begin
        wr_live = wr_en && (wr_idx != '0);
        st_d    = st_q;
        if (wr_live) begin
            st_d.r[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    function automatic logic [GPR_W-1:0] read_reg(
        input gp_state_t        s,
        input logic [IDX_W-1:0] idx,
        input logic             live,
        input logic [IDX_W-1:0] widx,
        input logic [GPR_W-1:0] wdata
    );
        if (idx == '0) begin
            return '0;
        end
        if (WRITE_FIRST && live && widx == idx) begin
            return wdata;
        end
        return s.r[idx];
    endfunction

    always_comb begin
        rd0_data = read_reg(st_q, rd0_idx, wr_live, wr_idx, wr_data);
        rd1_data = read_reg(st_q, rd1_idx, wr_live, wr_idx, wr_data);
    end

    AST_GP_ZERO_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == '0) |=> st_q.r[0] == '0); // R10

    AST_GP_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != '0) |=> st_q.r[$past(wr_idx)] == $past(wr_data)); // R9

    AST_GP_RESET: assert property (@(posedge clk)
        !rst_n |=> st_q == '0); // R8

endmodule

// File: rtl/vreg_alias_file.sv
module vreg_alias_file
    import vra_pkg::*;
#(
    parameter int  FP_ENTRIES  = 32,
    parameter int  VEC_W       = 256,
    parameter int  GP_ENTRIES  = 32,
    parameter int  GPR_W       = 64,
    parameter bit  WRITE_FIRST = 1'b0,
    localparam int FIDX_W      = $clog2(FP_ENTRIES),
    localparam int GIDX_W      = $clog2(GP_ENTRIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vw_en,
    input  logic [FIDX_W-1:0]   vw_idx,
    input  logic [1:0]          vw_view,
    input  logic [VEC_W-1:0]    vw_data,
    input  logic [FIDX_W-1:0]   vr0_idx,
    input  logic [1:0]          vr0_view,
    output logic [VEC_W-1:0]    vr0_data,
    input  logic [FIDX_W-1:0]   vr1_idx,
    input  logic [1:0]          vr1_view,
    output logic [VEC_W-1:0]    vr1_data,
    input  logic                gw_en,
    input  logic [GIDX_W-1:0]   gw_idx,
    input  logic [GPR_W-1:0]    gw_data,
    input  logic [GIDX_W-1:0]   gr0_idx,
    output logic [GPR_W-1:0]    gr0_data,
    input  logic [GIDX_W-1:0]   gr1_idx,
    output logic [GPR_W-1:0]    gr1_data
);
    localparam int NRD = 2;
    localparam int QW  = VEC_W / 4;
    localparam int HW  = VEC_W / 2;

    logic [VEC_W-1:0]  wr_merged;
    logic [VEC_W-1:0]  raw   [NRD];
    logic [FIDX_W-1:0] r_idx [NRD];
    view_e             r_view[NRD];
    logic [VEC_W-1:0]  r_data[NRD];

    always_comb begin
        r_idx[0]  = vr0_idx;
        r_idx[1]  = vr1_idx;
        r_view[0] = view_e'(vr0_view);
        r_view[1] = view_e'(vr1_view);
        vr0_data  = r_data[0];
        vr1_data  = r_data[1];
    end

    vra_fp_bank #(.ENTRIES(FP_ENTRIES), .VEC_W(VEC_W)) u_fp (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (vw_en),
        .wr_idx    (vw_idx),
        .wr_view   (view_e'(vw_view)),
        .wr_data   (vw_data),
        .wr_merged (wr_merged),
        .rd0_idx   (vr0_idx),
        .rd0_raw   (raw[0]),
        .rd1_idx   (vr1_idx),
        .rd1_raw   (raw[1])
    );

    generate
        for (genvar p = 0; p < NRD; p++) begin : g_rd
            vra_read_port #(
                .VEC_W(VEC_W), .IDX_W(FIDX_W), .WRITE_FIRST(WRITE_FIRST)
            ) u_port (
                .rd_idx    (r_idx[p]),
                .rd_view   (r_view[p]),
                .rd_raw    (raw[p]),
                .wr_en     (vw_en),
                .wr_idx    (vw_idx),
                .wr_merged (wr_merged),
                .rd_data   (r_data[p])
            );
        end
    endgenerate

    vra_gp_bank #(.ENTRIES(GP_ENTRIES), .GPR_W(GPR_W), .WRITE_FIRST(WRITE_FIRST)) u_gp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (gw_en),
        .wr_idx   (gw_idx),
        .wr_data  (gw_data),
        .rd0_idx  (gr0_idx),
        .rd0_data (gr0_data),
        .rd1_idx  (gr1_idx),
        .rd1_data (gr1_data)
    );

    AST_S64_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (vr0_view == 2'd0) |-> vr0_data[VEC_W-1:QW] == '0); // R5

    AST_V128_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (vr1_view == 2'd1) |-> vr1_data[VEC_W-1:HW] == '0); // R5

    AST_GP_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (gr0_idx == '0) |-> gr0_data == '0); // R10

    AST_SAME_ENTRY_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (vr0_idx == vr1_idx && vr0_view == 2'd0 && vr1_view == 2'd2) |->
            vr0_data[QW-1:0] == vr1_data[QW-1:0]); // R1

endmodule

// File: tb/vreg_alias_file_bench.sv
module vreg_alias_file_bench;
    localparam int VW = 256;
    localparam int GW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vw_en = 1'b0;
    logic [4:0]    vw_idx = '0;
    logic [1:0]    vw_view = '0;
    logic [VW-1:0] vw_data = '0;
    logic [4:0]    vr0_idx = '0, vr1_idx = '0;
    logic [1:0]    vr0_view = '0, vr1_view = '0;
    logic [VW-1:0] vr0_data, vr1_data;
    logic          gw_en = 1'b0;
    logic [4:0]    gw_idx = '0;
    logic [GW-1:0] gw_data = '0;
    logic [4:0]    gr0_idx = '0, gr1_idx = '0;
    logic [GW-1:0] gr0_data, gr1_data;

    int checks = 0;
    int errors = 0;
    logic [VW-1:0] fp_ref [32];
    logic [GW-1:0] gp_ref [32];

    always #10 clk = ~clk;

    vreg_alias_file u_vreg_alias_file (
        .clk(clk), .rst_n(rst_n),
        .vw_en(vw_en), .vw_idx(vw_idx), .vw_view(vw_view), .vw_data(vw_data),
        .vr0_idx(vr0_idx), .vr0_view(vr0_view), .vr0_data(vr0_data),
        .vr1_idx(vr1_idx), .vr1_view(vr1_view), .vr1_data(vr1_data),
        .gw_en(gw_en), .gw_idx(gw_idx), .gw_data(gw_data),
        .gr0_idx(gr0_idx), .gr0_data(gr0_data),
        .gr1_idx(gr1_idx), .gr1_data(gr1_data)
    );

    function automatic logic [VW-1:0] view_mask(input logic [1:0] v);
        if (v == 2'd0) return {{(VW-64){1'b0}}, {64{1'b1}}};
        if (v == 2'd1) return {{(VW-128){1'b0}}, {128{1'b1}}};
        return '1;
    endfunction

    function automatic logic [VW-1:0] exp_merge(input logic [VW-1:0] old,
                                                 input logic [VW-1:0] d,
                                                 input logic [1:0] v);
        return (old & ~view_mask(v)) | (d & view_mask(v));
    endfunction

    function automatic logic [VW-1:0] rand_wide();
        logic [VW-1:0] r;
        for (int k = 0; k < VW / 32; k++) r[k*32 +: 32] = $urandom();
        return r;
    endfunction

    task automatic chk_v(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_g(input string tag, input logic [GW-1:0] act, input logic [GW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string fp_tag(input logic [4:0] ri, input logic [1:0] rv, input string forced);
        if (forced != "") return forced;
        if (vw_en && vw_idx == ri) return "R7 fp read during write";
        if (rv != 2'd2 && rv != 2'd3) return "R5 narrow read";
        return "R6 wide read";
    endfunction

    function automatic string gp_tag(input logic [4:0] ri);
        if (ri == 5'd0) return "R10 gp zero";
        if (gw_en && gw_idx == ri) return "R7 gp read during write";
        return "R9 gp read";
    endfunction

    // Inputs are already driven after a falling edge; check reads, then clock, then update model
    task automatic run_cycle(input string tag);
        #5;
        chk_v(fp_tag(vr0_idx, vr0_view, tag), vr0_data, fp_ref[vr0_idx] & view_mask(vr0_view));
        chk_v(fp_tag(vr1_idx, vr1_view, tag), vr1_data, fp_ref[vr1_idx] & view_mask(vr1_view));
        chk_g(gp_tag(gr0_idx), gr0_data, (gr0_idx == 0) ? '0 : gp_ref[gr0_idx]);
        chk_g(gp_tag(gr1_idx), gr1_data, (gr1_idx == 0) ? '0 : gp_ref[gr1_idx]);
        @(posedge clk);
        if (vw_en) fp_ref[vw_idx] = exp_merge(fp_ref[vw_idx], vw_data, vw_view);
        if (gw_en && gw_idx != 0) gp_ref[gw_idx] = gw_data;
        @(negedge clk);
    endtask

    task automatic idle();
        vw_en = 1'b0;
        gw_en = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 32; i++) begin
            fp_ref[i] = '0;
            gp_ref[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: everything zero after reset, read every entry wide
        idle();
        for (int i = 0; i < 32; i++) begin
            vr0_idx = 5'(i); vr0_view = 2'd2;
            vr1_idx = 5'(31 - i); vr1_view = 2'd3;
            gr0_idx = 5'(i); gr1_idx = 5'(31 - i);
            run_cycle("R8 reset state");
        end

        // R4: fill entry 5 with ones
        vw_en = 1'b1; vw_idx = 5'd5; vw_view = 2'd2; vw_data = '1;
        vr0_idx = 5'd5; vr0_view = 2'd2; vr1_idx = 5'd6; vr1_view = 2'd2;
        run_cycle("R4 full write");
        // R2: 64-bit write keeps upper 192 ones
        vw_view = 2'd0; vw_data = {4{64'h0123_4567_89AB_CDEF}};
        run_cycle("R7 read-first old value");
        idle();
        run_cycle("R2 64-bit merge");
        // R3: 128-bit write keeps upper 128 bits
        vw_en = 1'b1; vw_view = 2'd1; vw_data = '0;
        run_cycle("");
        idle();
        vr1_idx = 5'd5; vr1_view = 2'd0;
        run_cycle("R3 128-bit merge");
        // R5: narrow reads after a wide write
        vw_en = 1'b1; vw_idx = 5'd9; vw_view = 2'd3; vw_data = rand_wide();
        run_cycle("");
        idle();
        vr0_idx = 5'd9; vr0_view = 2'd0; vr1_idx = 5'd9; vr1_view = 2'd1;
        run_cycle("R5 narrow read of wide write");
        // R9: disabled write with data on the bus has no effect
        vw_idx = 5'd9; vw_data = '0; vw_view = 2'd2;
        gw_idx = 5'd3; gw_data = 64'hDEAD_BEEF_0000_0001;
        run_cycle("R9 no write without enable");
        vr0_view = 2'd2;
        gr0_idx = 5'd3;
        run_cycle("R9 no write without enable");
        // R10: write register 0, read it back
        gw_en = 1'b1; gw_idx = 5'd0; gw_data = '1;
        gr0_idx = 5'd0;
        run_cycle("");
        idle();
        run_cycle("");

        // random traffic with frequent index collisions
        for (int n = 0; n < 3000; n++) begin
            logic narrow;
            narrow = $urandom_range(0, 1) == 1;
            vw_en   = $urandom_range(0, 3) != 0;
            vw_idx  = narrow ? 5'($urandom_range(0, 3)) : 5'($urandom_range(0, 31));
            vw_view = 2'($urandom_range(0, 3));
            vw_data = rand_wide();
            vr0_idx = narrow ? 5'($urandom_range(0, 3)) : 5'($urandom_range(0, 31));
            vr1_idx = narrow ? 5'($urandom_range(0, 3)) : 5'($urandom_range(0, 31));
            vr0_view = 2'($urandom_range(0, 3));
            vr1_view = 2'($urandom_range(0, 3));
            gw_en   = $urandom_range(0, 2) != 0;
            gw_idx  = narrow ? 5'($urandom_range(0, 3)) : 5'($urandom_range(0, 31));
            gw_data = {$urandom(), $urandom()};
            gr0_idx = narrow ? 5'($urandom_range(0, 3)) : 5'($urandom_range(0, 31));
            gr1_idx = 5'($urandom_range(0, 31));
            run_cycle("");
        end

        // R8: reset in the middle clears again
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 32; i++) begin
            fp_ref[i] = '0;
            gp_ref[i] = '0;
        end
        for (int i = 0; i < 32; i++) begin
            vr0_idx = 5'(i); vr0_view = 2'd2; vr1_idx = 5'(i); vr1_view = 2'd1;
            gr0_idx = 5'(i); gr1_idx = 5'(i);
            run_cycle("R8 reset state");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule